// File: doc/BRIEF.md
# Input capture unit with digital noise filter

This block snapshots a free-running counter value into a capture register when a chosen transition shows up on an asynchronous external pin. The pin is first brought into the clock domain. It then goes through an optional digital filter, which runs at the full system clock and only accepts a new level after several consecutive samples agree. A transition of the selected polarity on the resulting clean level copies the counter into the capture register. In the same cycle a one-clock event flag is raised.

The counter is supplied from outside. The capture register is a plain output, and the event flag is meant to drive an interrupt or a DMA request elsewhere. The polarity-select bit and the filter-enable bit are plain level inputs, so register storage for them lives outside the block.

Top module: `icap_unit`

## Requirements
- R1: While reset is asserted and after it is released, `cap_val_o` is 0 and `cap_evt_o` is 0. The synchronized and filtered pin levels reset low, so the pin must idle low across reset. A pin that is high after reset counts as a rising transition.
- R2: With `filt_en_i` = 0, a pin level that first holds at the sampling clock edge k produces its capture at edge k+3, which is two synchronizer stages plus one filter/edge stage.
- R3: With `edge_sel_i` = 0 only high-to-low transitions capture. With `edge_sel_i` = 1 only low-to-high transitions capture. A transition of the other polarity changes neither output.
- R4: With `filt_en_i` = 1, the filtered level changes only after 4 consecutive clock samples of the synchronized pin show the new level. A pin level held for 3 or fewer clock samples produces no capture.
- R5: With `filt_en_i` = 1, a level first held at edge k and kept for at least 4 samples captures at edge k+6.
- R6: On a capture, `cap_val_o` takes the value `count_i` had at the capturing clock edge.
- R7: `cap_evt_o` is high for exactly one clock, in the cycle after `cap_val_o` is loaded. `cap_val_o` holds its value in every cycle without a capture.
- R8: Changing `edge_sel_i` or `filt_en_i` while the filtered pin level is static produces no capture.
- R9: A qualified transition produces exactly one capture, however long the new level is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; also the filter sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_pin_i | input | 1 | Asynchronous external capture pin |
| count_i | input | CNT_W | Free-running counter value to be captured |
| edge_sel_i | input | 1 | Polarity select: 0 falling, 1 rising |
| filt_en_i | input | 1 | Noise filter enable |
| cap_val_o | output | CNT_W | Capture register |
| cap_evt_o | output | 1 | One-cycle capture event |

## Verification
Single clean transitions of both polarities, with the filter off and then on, check the polarity rule. They also check the exact capture latency, which is the only visible difference between the bypass and filtered paths. Pulses held for exactly three and exactly four samples bracket the filter threshold. Long holds show that a transition fires once and not repeatedly. Toggling the polarity and filter bits on a static pin tells a true edge apart from a change in the comparison target. Random run lengths from one to eight cycles, with random mode changes, are compared cycle by cycle against a sample-history model of the requirements.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;

  localparam int MinSyncStages = 2;
  localparam int MinFiltLen    = 2;

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lvl_i,
  output logic lvl_o
);

  localparam int HistW = LEN - 1;

  logic [HistW-1:0] hist_q;
  logic             lvl_q;
  logic             all_hi;
  logic             all_lo;

  // history keeps shifting while bypassed so enabling mid-stream needs no refill
  generate
    if (HistW > 1) begin : g_hist_wide
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= {hist_q[HistW-2:0], lvl_i};
      end
    end else begin : g_hist_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= lvl_i;
      end
    end
  endgenerate

  assign all_hi = &{hist_q, lvl_i};
  assign all_lo = ~|{hist_q, lvl_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lvl_q <= 1'b0;
    else if (!en_i)  lvl_q <= lvl_i;
    else if (all_hi) lvl_q <= 1'b1;
    else if (all_lo) lvl_q <= 1'b0;
  end

  assign lvl_o = lvl_q;

endmodule

// File: rtl/icap_edge.sv
module icap_edge
  import icap_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  edge_pol_e pol_i,
  output logic      hit_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  // a polarity change alone cannot fire: a level change is required
  assign hit_o = (lvl_i != prev_q) && (lvl_i == (pol_i == EDGE_RISE));

endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = MinSyncStages,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             edge_sel_i,
  input  logic             filt_en_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_evt_o
);

  logic             sync_lvl;
  logic             flt_lvl;
  logic             hit;
  logic [CNT_W-1:0] cap_q;
  logic             evt_q;

  icap_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cap_pin_i),
    .q_o    (sync_lvl)
  );

  icap_filter #(
    .LEN    (FILT_LEN)
  ) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (filt_en_i),
    .lvl_i  (sync_lvl),
    .lvl_o  (flt_lvl)
  );

  icap_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (flt_lvl),
    .pol_i  (edge_pol_e'(edge_sel_i)),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= hit;
      if (hit) cap_q <= count_i;
    end
  end

  assign cap_val_o = cap_q;
  assign cap_evt_o = evt_q;

endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
  parameter int CNT_W    = 16,
  parameter int FILT_LEN = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_i,
  input logic             edge_sel_i,
  input logic             filt_en_i,
  input logic             sync_lvl,
  input logic             flt_lvl,
  input logic [CNT_W-1:0] cap_val_o,
  input logic             cap_evt_o
);

  localparam int RunW = $clog2(FILT_LEN + 1);
  localparam logic [RunW-1:0] RunMax = RunW'(FILT_LEN);

  logic [RunW-1:0] run_q;
  logic            prev_sync_q;

  // length of the current run of equal synchronized samples, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= '0;
      prev_sync_q <= 1'b0;
    end else begin
      prev_sync_q <= sync_lvl;
      if (sync_lvl != prev_sync_q) run_q <= RunW'(1);
      else if (run_q != RunMax)    run_q <= run_q + RunW'(1);
    end
  end

  AST_BYPASS_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(filt_en_i) |-> flt_lvl == $past(sync_lvl)); // R2

  AST_FILT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(filt_en_i) && flt_lvl != $past(flt_lvl)) |->
      (run_q == RunMax && prev_sync_q == flt_lvl)); // R4

  AST_EVT_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_o |-> ($past(flt_lvl) == $past(edge_sel_i))); // R3

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flt_lvl) == $past(flt_lvl, 2)) |-> !cap_evt_o); // R8

  AST_CAP_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_o |-> cap_val_o == $past(count_i)); // R6

  AST_EVT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_o |=> !cap_evt_o); // R9

  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_evt_o |-> $stable(cap_val_o)); // R7

endmodule

bind icap_unit icap_unit_chk #(
  .CNT_W    (CNT_W),
  .FILT_LEN (FILT_LEN)
) i_icap_unit_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .count_i    (count_i),
  .edge_sel_i (edge_sel_i),
  .filt_en_i  (filt_en_i),
  .sync_lvl   (sync_lvl),
  .flt_lvl    (flt_lvl),
  .cap_val_o  (cap_val_o),
  .cap_evt_o  (cap_evt_o)
);

// File: tb/test_icap_unit.sv
module test_icap_unit;

  localparam int CNT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cap_pin_i = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic             edge_sel_i = 1'b0;
  logic             filt_en_i = 1'b0;
  logic [CNT_W-1:0] cap_val_o;
  logic             cap_evt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  icap_unit i_icap_unit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_pin_i  (cap_pin_i),
    .count_i    (count_i),
    .edge_sel_i (edge_sel_i),
    .filt_en_i  (filt_en_i),
    .cap_val_o  (cap_val_o),
    .cap_evt_o  (cap_evt_o)
  );

  always #10 clk_i = ~clk_i;

  always @(negedge clk_i) count_i <= count_i + 16'd1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // requirement model: pin sample history, two-sample delay into the level decision
  function automatic logic next_level(input logic en, input logic cur,
                                      input logic a, input logic b, input logic c, input logic d);
    if (!en) return a;
    if (a && b && c && d) return 1'b1;
    if (!a && !b && !c && !d) return 1'b0;
    return cur;
  endfunction

  logic [4:0]       ph;
  logic             lvl_m;
  logic             trn_m;
  logic             exp_evt;
  logic [CNT_W-1:0] exp_val;
  logic [CNT_W-1:0] edge_cnt;
  bit               model_on = 1'b0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph <= '0; lvl_m <= 1'b0; trn_m <= 1'b0;
      exp_evt <= 1'b0; exp_val <= '0; edge_cnt <= '0;
    end else begin
      logic nxt;
      nxt = next_level(filt_en_i, lvl_m, ph[1], ph[2], ph[3], ph[4]);
      edge_cnt <= count_i;
      ph <= {ph[3:0], cap_pin_i};
      trn_m <= (nxt != lvl_m);
      lvl_m <= nxt;
      exp_evt <= trn_m && (lvl_m == edge_sel_i);
      if (trn_m && (lvl_m == edge_sel_i)) exp_val <= count_i;
    end
  end

  always @(negedge clk_i) begin
    if (model_on && !done) begin
      chk(cap_evt_o == exp_evt, filt_en_i ? "R4 R7 event" : "R2 R7 event",
          32'(cap_evt_o), 32'(exp_evt));
      chk(cap_val_o == exp_val, "R6 value", 32'(cap_val_o), 32'(exp_val));
    end
  end

  task automatic count_evts(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      if (cap_evt_o) n++;
    end
  endtask

  task automatic settle(input logic lvl);
    int n;
    cap_pin_i = lvl;
    count_evts(12, n);
  endtask

  task automatic latency(input logic en, input logic sel, input int exp_k, input string tag);
    int k;
    filt_en_i = en;
    edge_sel_i = sel;
    settle(~sel);
    @(negedge clk_i);
    cap_pin_i = sel;
    k = -1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i);
      if (cap_evt_o && k < 0) begin
        k = i;
        chk(cap_val_o == edge_cnt, "R6 captured count", 32'(cap_val_o), 32'(edge_cnt));
      end
    end
    chk(k == exp_k, tag, 32'(k), 32'(exp_k));
  endtask

  task automatic pulse(input int width, input int exp_n, input string tag);
    int n;
    filt_en_i = 1'b1;
    edge_sel_i = 1'b1;
    settle(1'b0);
    @(negedge clk_i);
    cap_pin_i = 1'b1;
    for (int i = 0; i < width; i++) @(negedge clk_i);
    cap_pin_i = 1'b0;
    count_evts(14, n);
    chk(n == exp_n, tag, 32'(n), 32'(exp_n));
  endtask

  initial begin
    int n;
    int seed;
    seed = $urandom(32'd1317);
    count_i = 16'($urandom);
    repeat (3) @(negedge clk_i);
    chk(cap_val_o == '0 && cap_evt_o == 1'b0, "R1 in reset", 32'({cap_val_o, cap_evt_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    model_on = 1'b1;
    count_evts(6, n);
    chk(cap_val_o == '0 && n == 0, "R1 after reset", 32'(n), 0);

    // R2 R5 latency, R3 both polarities
    latency(1'b0, 1'b1, 3, "R2 rise latency");
    latency(1'b0, 1'b0, 3, "R3 fall latency");
    latency(1'b1, 1'b1, 6, "R5 rise latency");
    latency(1'b1, 1'b0, 6, "R5 fall latency");

    // R3 opposite polarity ignored
    edge_sel_i = 1'b1; filt_en_i = 1'b0;
    settle(1'b1);
    cap_pin_i = 1'b0;
    count_evts(12, n);
    chk(n == 0, "R3 falling ignored when rising selected", 32'(n), 0);

    // R4 threshold
    pulse(3, 0, "R4 three-sample pulse rejected");
    pulse(4, 1, "R4 four-sample pulse accepted");
    pulse(1, 0, "R4 one-sample glitch rejected");

    // R9 long hold
    filt_en_i = 1'b0; edge_sel_i = 1'b1;
    settle(1'b0);
    cap_pin_i = 1'b1;
    count_evts(40, n);
    chk(n == 1, "R9 single capture on long hold", 32'(n), 1);

    // R8 control changes on static pin
    for (int i = 0; i < 24; i++) begin
      @(negedge clk_i);
      edge_sel_i = ~edge_sel_i;
      if (i % 3 == 0) filt_en_i = ~filt_en_i;
      if (cap_evt_o) n++;
    end
    chk(n == 1, "R8 no capture from control toggles", 32'(n - 1), 0);

    // random runs, random modes; the model checks every cycle
    for (int ph_i = 0; ph_i < 40; ph_i++) begin
      filt_en_i = 1'($urandom_range(0, 1));
      edge_sel_i = 1'($urandom_range(0, 1));
      for (int r = 0; r < 40; r++) begin
        cap_pin_i = 1'($urandom_range(0, 1));
        repeat ($urandom_range(1, 8)) @(negedge clk_i);
        if ($urandom_range(0, 15) == 0) edge_sel_i = ~edge_sel_i;
        if ($urandom_range(0, 15) == 0) filt_en_i = ~filt_en_i;
      end
    end
    settle(1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule